// File: doc/BRIEF.md
# Raster Resampling Address Sequencer

This block drives the address side of an image resampling engine. It walks a rectangle of target pixels (U columns, V rows) in raster order. For every target pixel it produces the source-image coordinates (X, Y) that the pixel arithmetic must fetch. Source coordinates are generated from an origin and signed integer step values. Target coordinates follow the source stream at a fixed lag, so that the write of a result lines up with its address.

Two kernel modes are selectable. In nearest-neighbour mode the block issues one source fetch per target pixel. In bilinear mode it issues four fetches that cover the 2x2 neighbourhood of each pixel. The block also produces an accumulator-clear strobe and a write strobe, plus three early-warning flags that let downstream logic prepare for a row turn, for the last row, and for the end of the frame. A select input adds one clock of delay to both strobes, for downstream pipelines that need it.

All outputs are plain registered signals. The sequencer runs at one address per clock and applies no back-pressure. A consumer that cannot keep up must be stalled by gating the clock, or by holding INIT and restarting. The bounds, origin, steps and mode inputs must stay stable from INIT until the frame has finished. The bounds must satisfy UMAX >= UMIN+2 and VMAX >= VMIN.

Top module: `resample_seq`

## Requirements
- R1: While rst_n is low, and in the cycle after any clock edge with init_i high, every output is 0. After reset the block stays idle until an init_i pulse occurs.
- R2: Edge #0 is the first rising edge with init_i low. After edge #2, x_o equals x_org_i and y_o equals y_org_i.
- R3: In nearest mode (bilin_i=0), each row issues N = u_max_i-u_min_i+2 source addresses. Address k of the row is X = x_org_i + k*dx_i, where the steps are two's complement and X wraps modulo 2^AW. Row r has Y = y_org_i + r*dy_i. u_o/v_o show the target (u_min_i+k, v_min_i+r) one clock after the matching X, so the last U of a row equals u_max_i+1.
- R4: end_row_o is a one-clock pulse that is high 3 cycles before the last source address of each row. In nearest mode this is the address with U = u_max_i-2. In bilinear mode it is the first tap of the pixel at U = u_max_i+1.
- R5: end_col_o is high while source addresses of the row at v_max_i are issued. It goes low in the cycle in which done_o rises, and it stays low for the rest of that row.
- R6: done_o is high for exactly one clock, in the cycle just before the last source address of the frame.
- R7: With auto_i=1, the first address of the next frame (x_org_i, y_org_i) follows the last address of the frame with no gap, and u_o/v_o return to u_min_i/v_min_i one cycle after showing u_max_i+1/v_max_i. With auto_i=0, the sequencer stops after the frame: addresses hold their last values and all strobes and flags are 0.
- R8: pipe_i=1 delays wr_stb_o and acc_clr_o by exactly one clock relative to pipe_i=0. No other output changes.
- R9: In bilinear mode (bilin_i=1), each target pixel takes 4 clocks. The taps use source offsets (dX,dY) of (0,0), (1,0), (1,1) and (0,1), in that order, added to the pixel's base X and Y.
- R10: In bilinear mode with pipe_i=0, acc_clr_o is high on the first tap of every pixel. wr_stb_o pulses for one clock in the cycle in which u_o/v_o change to the pixel whose four taps have just finished.
- R11: In nearest mode with pipe_i=0, wr_stb_o is high from edge #2 on, for every cycle in which a source address is issued. acc_clr_o is high with every source address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous start; sequence begins when it falls |
| auto_i | input | 1 | Restart the frame automatically at its end |
| bilin_i | input | 1 | 1: 2x2 bilinear walk, 0: nearest neighbour |
| pipe_i | input | 1 | Add one clock to the write and accumulate strobes |
| u_min_i | input | AW | First target column |
| u_max_i | input | AW | Last real target column |
| v_min_i | input | AW | First target row |
| v_max_i | input | AW | Last target row |
| x_org_i | input | AW | Source X at the start of each row |
| y_org_i | input | AW | Source Y of the first row |
| dx_i | input | SW | Signed source X step per target pixel |
| dy_i | input | SW | Signed source Y step per target row |
| x_o | output | AW | Source X address |
| y_o | output | AW | Source Y address |
| u_o | output | AW | Target U address |
| v_o | output | AW | Target V address |
| wr_stb_o | output | 1 | Target write strobe |
| acc_clr_o | output | 1 | Start a new accumulation |
| end_row_o | output | 1 | Early row-end flag |
| end_col_o | output | 1 | Final-row flag |
| done_o | output | 1 | Frame-end flag |

## Verification
Some properties are checked on every cycle. The flag shapes are: end_row_o and done_o never last longer than one clock, end_col_o is low whenever done_o is high, and bilinear accumulation pulses never touch each other. A further check confirms that init_i clears every strobe and flag on the next edge. The absolute timing can only be shown by the bench scenarios. This covers the exact address values, the two-clock start latency, the one-clock lag of U/V, the gap-free frame wrap, the halt when auto-restart is off, and the one-clock shift from pipe_i. The bench compares every output on every cycle against a closed-form model built from the frame geometry.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  // sequencer control phases: two warm-up clocks after INIT, then running
  typedef enum logic [1:0] {SQ_IDLE, SQ_WARM0, SQ_WARM1, SQ_RUN} sq_state_e;
endpackage

// File: rtl/rsq_tap_decode.sv
module rsq_tap_decode #(
  parameter int AW = 12
) (
  input  logic          bilin,
  input  logic [1:0]    tap,
  input  logic [AW-1:0] pu,
  input  logic [AW-1:0] pv,
  input  logic [AW-1:0] sx,
  input  logic [AW-1:0] sy,
  input  logic [AW-1:0] u_max,
  input  logic [AW-1:0] v_max,
  output logic [AW-1:0] ex,
  output logic [AW-1:0] ey,
  output logic          first_tap,
  output logic          last_tap,
  output logic          row_end,
  output logic          last_row,
  output logic          end_row,
  output logic          end_col,
  output logic          done
);
  logic [AW-1:0] u_end;
  logic          x_off, y_off;

  always_comb begin
    u_end     = u_max + AW'(1);
    row_end   = (pu == u_end);
    last_row  = (pv == v_max);
    first_tap = (tap == 2'd0);
    last_tap  = !bilin || (tap == 2'd3);
    // kernel order (0,0) (1,0) (1,1) (0,1)
    x_off     = bilin && (tap == 2'd1 || tap == 2'd2);
    y_off     = bilin && tap[1];
    ex        = sx + AW'(x_off);
    ey        = sy + AW'(y_off);
    if (bilin) begin
      end_row = row_end && (tap == 2'd0);
      done    = last_row && row_end && (tap == 2'd2);
      end_col = last_row && !(row_end && tap[1]);
    end else begin
      end_row = (pu == u_max - AW'(2));
      done    = last_row && (pu == u_max);
      end_col = last_row && (pu < u_max);
    end
  end
endmodule

// File: rtl/rsq_scan.sv
module rsq_scan
  import rsq_pkg::*;
#(
  parameter int AW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          auto_en,
  input  logic [AW-1:0] u_min,
  input  logic [AW-1:0] v_min,
  input  logic [AW-1:0] x_org,
  input  logic [AW-1:0] y_org,
  input  logic [SW-1:0] dx,
  input  logic [SW-1:0] dy,
  input  logic          last_tap,
  input  logic          row_end,
  input  logic          last_row,
  output logic          go,
  output logic [1:0]    tap,
  output logic [AW-1:0] pu,
  output logic [AW-1:0] pv,
  output logic [AW-1:0] sx,
  output logic [AW-1:0] sy
);
  localparam int EXT = AW - SW;

  sq_state_e     state;
  logic [AW-1:0] dx_ext, dy_ext;

  assign dx_ext = {{EXT{dx[SW-1]}}, dx};
  assign dy_ext = {{EXT{dy[SW-1]}}, dy};
  assign go     = (state == SQ_RUN) && !init;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SQ_IDLE;
      tap   <= '0;
      pu    <= '0;
      pv    <= '0;
      sx    <= '0;
      sy    <= '0;
    end else if (init) begin
      state <= SQ_WARM0;
      tap   <= '0;
      pu    <= u_min;
      pv    <= v_min;
      sx    <= x_org;
      sy    <= y_org;
    end else if (state == SQ_WARM0) begin
      state <= SQ_WARM1;
    end else if (state == SQ_WARM1) begin
      state <= SQ_RUN;
    end else if (go) begin
      if (!last_tap) begin
        tap <= tap + 2'd1;
      end else begin
        tap <= '0;
        if (!row_end) begin
          pu <= pu + AW'(1);
          sx <= sx + dx_ext;
        end else begin
          pu <= u_min;
          sx <= x_org;
          if (!last_row) begin
            pv <= pv + AW'(1);
            sy <= sy + dy_ext;
          end else begin
            pv <= v_min;
            sy <= y_org;
            if (!auto_en) state <= SQ_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rsq_strobe_dly.sv
module rsq_strobe_dly #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         sel,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   held <= '0;
    else if (clr) held <= '0;
    else          held <= d;
  end

  assign q = sel ? held : d;
endmodule

// File: rtl/resample_seq.sv
module resample_seq #(
  parameter int AW = 12,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init_i,
  input  logic          auto_i,
  input  logic          bilin_i,
  input  logic          pipe_i,
  input  logic [AW-1:0] u_min_i,
  input  logic [AW-1:0] u_max_i,
  input  logic [AW-1:0] v_min_i,
  input  logic [AW-1:0] v_max_i,
  input  logic [AW-1:0] x_org_i,
  input  logic [AW-1:0] y_org_i,
  input  logic [SW-1:0] dx_i,
  input  logic [SW-1:0] dy_i,
  output logic [AW-1:0] x_o,
  output logic [AW-1:0] y_o,
  output logic [AW-1:0] u_o,
  output logic [AW-1:0] v_o,
  output logic          wr_stb_o,
  output logic          acc_clr_o,
  output logic          end_row_o,
  output logic          end_col_o,
  output logic          done_o
);
  logic          go;
  logic [1:0]    tap;
  logic [AW-1:0] pu, pv, sx, sy, ex, ey;
  logic          first_tap, last_tap, row_end, last_row;
  logic          fl_row, fl_col, fl_done;

  rsq_scan #(.AW(AW), .SW(SW)) u_scan (
    .clk(clk), .rst_n(rst_n), .init(init_i), .auto_en(auto_i),
    .u_min(u_min_i), .v_min(v_min_i), .x_org(x_org_i), .y_org(y_org_i),
    .dx(dx_i), .dy(dy_i),
    .last_tap(last_tap), .row_end(row_end), .last_row(last_row),
    .go(go), .tap(tap), .pu(pu), .pv(pv), .sx(sx), .sy(sy)
  );

  rsq_tap_decode #(.AW(AW)) u_dec (
    .bilin(bilin_i), .tap(tap), .pu(pu), .pv(pv), .sx(sx), .sy(sy),
    .u_max(u_max_i), .v_max(v_max_i),
    .ex(ex), .ey(ey), .first_tap(first_tap), .last_tap(last_tap),
    .row_end(row_end), .last_row(last_row),
    .end_row(fl_row), .end_col(fl_col), .done(fl_done)
  );

  // stage 1 carries the target of the tap just issued
  logic          s1_v, s1_last;
  logic [AW-1:0] s1_pu, s1_pv;
  logic          wr0, acc0;
  logic [1:0]    stb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x_o <= '0; y_o <= '0; u_o <= '0; v_o <= '0;
      s1_v <= 1'b0; s1_last <= 1'b0; s1_pu <= '0; s1_pv <= '0;
      wr0 <= 1'b0; acc0 <= 1'b0;
      end_row_o <= 1'b0; end_col_o <= 1'b0; done_o <= 1'b0;
    end else if (init_i) begin
      x_o <= '0; y_o <= '0; u_o <= '0; v_o <= '0;
      s1_v <= 1'b0; s1_last <= 1'b0; s1_pu <= '0; s1_pv <= '0;
      wr0 <= 1'b0; acc0 <= 1'b0;
      end_row_o <= 1'b0; end_col_o <= 1'b0; done_o <= 1'b0;
    end else begin
      if (go) begin
        x_o <= ex;
        y_o <= ey;
      end
      s1_v    <= go;
      s1_last <= last_tap;
      s1_pu   <= pu;
      s1_pv   <= pv;
      if (s1_v && s1_last) begin
        u_o <= s1_pu;
        v_o <= s1_pv;
      end
      wr0       <= bilin_i ? (s1_v && s1_last) : go;
      acc0      <= go && first_tap;
      end_row_o <= go && fl_row;
      end_col_o <= go && fl_col;
      done_o    <= go && fl_done;
    end
  end

  rsq_strobe_dly #(.W(2)) u_dly (
    .clk(clk), .rst_n(rst_n), .clr(init_i), .sel(pipe_i),
    .d({wr0, acc0}), .q(stb_q)
  );
  assign wr_stb_o  = stb_q[1];
  assign acc_clr_o = stb_q[0];

  assert_init_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> !(wr_stb_o || acc_clr_o || end_row_o || end_col_o || done_o));
  assert_endrow_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    end_row_o |=> !end_row_o);
  assert_endcol_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !end_col_o);
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  assert_acc_spacing_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_clr_o && bilin_i) |=> !acc_clr_o);
endmodule

// File: tb/resample_seq_bench.sv
`timescale 1ns/1ps
module resample_seq_bench;
  localparam int AW = 12;
  localparam int SW = 8;
  localparam int MASK = (1 << AW) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic init_i = 1'b0, auto_i = 1'b0, bilin_i = 1'b0, pipe_i = 1'b0;
  logic [AW-1:0] u_min_i = '0, u_max_i = '0, v_min_i = '0, v_max_i = '0;
  logic [AW-1:0] x_org_i = '0, y_org_i = '0;
  logic [SW-1:0] dx_i = '0, dy_i = '0;
  logic [AW-1:0] x_o, y_o, u_o, v_o;
  logic wr_stb_o, acc_clr_o, end_row_o, end_col_o, done_o;

  always #4 clk = ~clk;

  resample_seq #(.AW(AW), .SW(SW)) u_resample_seq (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int c_umin, c_umax, c_vmin, c_vmax, c_xo, c_yo, c_dx, c_dy;
  bit c_auto, c_bil, c_pipe;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 190000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int taps();  return c_bil ? 4 : 1; endfunction
  function automatic int rowlen(); return (c_umax - c_umin + 2) * taps(); endfunction
  function automatic int frlen();  return rowlen() * (c_vmax - c_vmin + 1); endfunction

  // emission index of edge n, or -1 when no address is issued
  function automatic int emit(int n);
    int k = n - 2;
    if (k < 0) return -1;
    if (!c_auto && k >= frlen()) return -1;
    return k % frlen();
  endfunction

  function automatic int src_x(int e);
    int t = e % taps(), pix = (e % rowlen()) / taps();
    int off = (c_bil && (t == 1 || t == 2)) ? 1 : 0;
    return (c_xo + pix * c_dx + off) & MASK;
  endfunction
  function automatic int src_y(int e);
    int t = e % taps(), row = e / rowlen();
    int off = (c_bil && t >= 2) ? 1 : 0;
    return (c_yo + row * c_dy + off) & MASK;
  endfunction

  function automatic bit wr0_at(int n);
    int e;
    if (!c_bil) return emit(n) >= 0;
    e = emit(n - 1);
    return e >= 0 && (e % 4) == 3;
  endfunction
  function automatic bit acc0_at(int n);
    int e = emit(n);
    return e >= 0 && (e % taps()) == 0;
  endfunction

  task automatic check_edge(int n);
    int k = n - 2, e, ehold, j, rp, pvi, eu, ev, ex, ey;
    string tg;
    e = emit(n);
    ehold = (k < 0) ? -1 : (c_auto ? k % frlen() : (k < frlen() ? k : frlen() - 1));
    ex = (ehold < 0) ? 0 : src_x(ehold);
    ey = (ehold < 0) ? 0 : src_y(ehold);
    tg = (n < 0) ? "R1" : (n == 2) ? "R2" : (k >= frlen()) ? "R7" : c_bil ? "R9" : "R3";
    chk(tg, "x_o", int'(x_o), ex);
    chk(tg, "y_o", int'(y_o), ey);
    // target of the most recent completed pixel, one clock later
    if (k < 1) j = -1;
    else if (c_bil) j = (k / 4) * 4 - 1;
    else j = k - 1;
    if (j >= 0 && !c_auto && j > frlen() - 1) j = frlen() - 1;
    if (j >= 0) begin
      j = j % frlen();
      eu = c_umin + (j % rowlen()) / taps();
      ev = c_vmin + j / rowlen();
    end else begin
      eu = 0; ev = 0;
    end
    tg = (n < 0) ? "R1" : (k - 1 >= frlen()) ? "R7" : "R3";
    chk(tg, "u_o", int'(u_o), eu);
    chk(tg, "v_o", int'(v_o), ev);
    tg = (n < 0) ? "R1" : c_pipe ? "R8" : c_bil ? "R10" : "R11";
    chk(tg, "wr_stb_o", int'(wr_stb_o), int'(c_pipe ? wr0_at(n - 1) : wr0_at(n)));
    chk(tg, "acc_clr_o", int'(acc_clr_o), int'(c_pipe ? acc0_at(n - 1) : acc0_at(n)));
    rp = (e < 0) ? -1 : e % rowlen();
    pvi = (e < 0) ? -1 : e / rowlen();
    chk((n < 0) ? "R1" : "R4", "end_row_o", int'(end_row_o), int'(e >= 0 && rp == rowlen() - 4));
    chk((n < 0) ? "R1" : "R5", "end_col_o", int'(end_col_o),
        int'(e >= 0 && pvi == c_vmax - c_vmin && rp < rowlen() - 2));
    chk((n < 0) ? "R1" : "R6", "done_o", int'(done_o),
        int'(e >= 0 && pvi == c_vmax - c_vmin && rp == rowlen() - 2));
  endtask

  task automatic run_scn(int umin, int umax, int vmin, int vmax, int xo, int yo,
                         int dx, int dy, bit au, bit bl, bit pp, int ncyc);
    c_umin = umin; c_umax = umax; c_vmin = vmin; c_vmax = vmax;
    c_xo = xo; c_yo = yo; c_dx = dx; c_dy = dy;
    c_auto = au; c_bil = bl; c_pipe = pp;
    @(negedge clk);
    u_min_i = AW'(umin); u_max_i = AW'(umax); v_min_i = AW'(vmin); v_max_i = AW'(vmax);
    x_org_i = AW'(xo); y_org_i = AW'(yo); dx_i = SW'(dx); dy_i = SW'(dy);
    auto_i = au; bilin_i = bl; pipe_i = pp;
    init_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check_edge(-1);  // R1: state right after the INIT edge
    init_i = 1'b0;
    for (int n = 0; n < ncyc; n++) begin
      @(posedge clk);
      @(negedge clk);
      check_edge(n);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state, and idle without INIT
    chk("R1", "x_o reset", int'(x_o), 0);
    chk("R1", "wr_stb_o reset", int'(wr_stb_o), 0);
    rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "acc_clr_o idle", int'(acc_clr_o), 0);
    chk("R1", "done_o idle", int'(done_o), 0);
    chk("R1", "u_o idle", int'(u_o), 0);

    // directed: unit-step nearest, two frames with wrap
    run_scn(0, 5, 0, 5, 0, 0, 1, 1, 1'b1, 1'b0, 1'b0, 100);
    // same with strobe pipeline
    run_scn(0, 5, 0, 5, 0, 0, 1, 1, 1'b1, 1'b0, 1'b1, 60);
    // bilinear, unit steps
    run_scn(0, 5, 0, 5, 0, 0, 1, 1, 1'b1, 1'b1, 1'b0, 200);
    // nearest, single-shot frame then halt
    run_scn(3, 6, 2, 4, 100, 50, -2, 3, 1'b0, 1'b0, 0, 40);
    // bilinear single-shot with pipeline, minimum row
    run_scn(7, 9, 1, 1, 4090, 4094, 3, -1, 1'b0, 1'b1, 1'b1, 30);
    // restart in the middle of a frame
    run_scn(0, 4, 0, 3, 10, 10, 1, 1, 1'b1, 1'b0, 1'b0, 9);
    run_scn(0, 4, 0, 3, 10, 10, 1, 1, 1'b1, 1'b0, 1'b0, 30);

    for (int i = 0; i < 12; i++) begin
      int um = int'($urandom_range(0, 20));
      int vm = int'($urandom_range(0, 10));
      int ux = um + int'($urandom_range(2, 6));
      int vx = vm + int'($urandom_range(0, 3));
      bit au = 1'($urandom_range(0, 1));
      bit bl = 1'($urandom_range(0, 1));
      bit pp = 1'($urandom_range(0, 1));
      int L = (ux - um + 2) * (vx - vm + 1) * (bl ? 4 : 1);
      run_scn(um, ux, vm, vx, int'($urandom_range(0, MASK)), int'($urandom_range(0, MASK)),
              int'($urandom_range(0, 6)) - 3, int'($urandom_range(0, 6)) - 3,
              au, bl, pp, au ? L + L / 2 + 6 : L + 8);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule